// File: doc/BRIEF.md
# FFT Pipeline Mode Controller

This block sequences a chain of radix-2 single-delay-feedback FFT stages, built for a largest transform of 2048 points across eleven stages. It runs one up-counter whose bits feed the stage multiplexer selects straight through. From a configured mode (transform length and count of interleaved streams) it reports which stage supplies the final spectrum, which stages get their clock enable, and what clock-rate division the mode calls for. Trailing stages that a shorter transform does not use are left without an enable.

The counter holds at zero until the first input sample arrives. From then on it counts every cycle. A new mode is taken only while no input is valid. Taking a mode clears the counter, so the next first sample starts a fresh frame. After the delay-line latency of the selected final stage has passed, an output-valid flag rises and stays high.

Top module: `fft_mode_ctrl`

## Requirements
- R1: After reset the mode is one 2048-point stream: out_stage = 11, stage_en = all ones, rate_shift = 0, stage_sel = 0 and out_valid = 0.
- R2: The counter stays at 0 while no sample has arrived. The sample seen with the first in_valid is sample 0. From then on the counter advances by one every cycle, whether or not in_valid is high, and wraps modulo 2048.
- R3: For stage s (1 to 11), stage_sel bit s-1 equals counter bit 11-s, so stage s toggles every 2^(11-s) cycles.
- R4: cfg_len is log2(2048/N): 0 selects 2048 points and out_stage 11, 1 selects 1024 points and out_stage 10, 2 selects 512 points and out_stage 9.
- R5: stage_en bit s-1 is 1 exactly when s <= out_stage. The enabled stages always form a contiguous group starting at stage 1.
- R6: cfg_streams is log2 of the interleaved stream count (0, 1 or 2). A mode is legal when cfg_streams <= cfg_len. rate_shift = cfg_len - cfg_streams, where 0 is full rate, 1 is half rate and 2 is quarter rate.
- R7: A load with an illegal mode (cfg_len = 3, or cfg_streams > cfg_len) is ignored: the mode outputs, the counter and out_valid are left as they were.
- R8: cfg_load is ignored in any cycle where in_valid is high.
- R9: An accepted load clears the counter, the running state and out_valid from the next cycle on.
- R10: out_valid rises when the counter first reaches LAT = 2048 - 2^cfg_len, that is LAT cycles after the first sample. It stays high until the next accepted load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An input sample is present this cycle |
| cfg_load | input | 1 | Request to take cfg_len and cfg_streams |
| cfg_len | input | 2 | log2 of max length over transform length |
| cfg_streams | input | 2 | log2 of interleaved stream count |
| stage_sel | output | 11 | Multiplexer select per stage, bit s-1 for stage s |
| stage_en | output | 11 | Clock enable per stage, bit s-1 for stage s |
| out_stage | output | 4 | Number of the stage that feeds the final output |
| rate_shift | output | 2 | log2 of the clock division for the mode |
| out_valid | output | 1 | Pipeline latency has elapsed since the first sample |

## Verification
The hardest case to reach is a configuration request that arrives while a frame is already running. A rejected request must leave the counter unchanged, and this can only be seen one cycle later in the select pattern and the sticky valid flag. The stimulus first runs each mode past its latency boundary, which takes more than two thousand cycles, with in_valid dropped early so that the counter is shown to run freely. While the counter is mid-count, it then issues illegal loads and a legal load that coincides with valid input. Each time it checks that the selects follow the uncleared count and that out_valid stays high.

// File: rtl/fftctl_pkg.sv
package fftctl_pkg;
    typedef struct packed {
        logic [1:0] len;   // log2(max length / length)
        logic [1:0] str;   // log2(stream count)
    } mode_t;
endpackage

// File: rtl/pipe_counter.sv
module pipe_counter #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          clear_i,
    output logic [CW-1:0] cnt_o,
    output logic          run_o
);
    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clear_i) begin
            s_d = '0;
        end else if (s_q.run || start_i) begin
            s_d.run = 1'b1;
            s_d.cnt = s_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o = s_q.cnt;
    assign run_o = s_q.run;

    // R2: nothing moves the count while idle
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.run && !start_i && !clear_i) |=> (cnt_o == '0 && !run_o));

    // R3: the last stage select (count LSB) toggles every running cycle
    assert_lsb_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && !clear_i) |=> (cnt_o[0] != $past(cnt_o[0])));
endmodule

// File: rtl/stage_map.sv
module stage_map #(
    parameter int STAGES = 11,
    parameter int STG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAGES-1:0] cnt_i,
    input  logic [1:0]        len_i,
    output logic [STAGES-1:0] sel_o,
    output logic [STAGES-1:0] en_o,
    output logic [STG_W-1:0]  out_stage_o,
    output logic [STAGES-1:0] lat_o
);
    localparam logic [STAGES:0] FULL = (STAGES+1)'(1) << STAGES;

    logic [STAGES:0] lat_w;

    always_comb begin
        out_stage_o = STG_W'(STAGES) - STG_W'(len_i);
        lat_w       = FULL - ((STAGES+1)'(1) << len_i);
        lat_o       = lat_w[STAGES-1:0];
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        // stage g+1 switches every 2^(STAGES-1-g) cycles
        assign sel_o[g] = cnt_i[STAGES-1-g];
        assign en_o[g]  = (STG_W'(g + 1) <= out_stage_o);
        if (g > 0) begin : g_chk
            // R5: no enabled stage behind a gated one
            assert_en_contig_R5: assert property (@(posedge clk) disable iff (!rst_n)
                en_o[g] |-> en_o[g-1]);
        end
    end
endmodule

// File: rtl/fft_mode_ctrl.sv
module fft_mode_ctrl #(
    parameter int STAGES     = 11,
    parameter int MAX_SHRINK = 2,
    parameter int STG_W      = $clog2(STAGES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              cfg_load,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_streams,
    output logic [STAGES-1:0] stage_sel,
    output logic [STAGES-1:0] stage_en,
    output logic [STG_W-1:0]  out_stage,
    output logic [1:0]        rate_shift,
    output logic              out_valid
);
    import fftctl_pkg::*;

    typedef struct packed {
        mode_t mode;
        logic  ovalid;
    } ctl_state_t;

    ctl_state_t r_d, r_q;

    logic              legal, accept, running;
    logic [STAGES-1:0] cnt, lat;

    always_comb begin
        legal  = (cfg_len <= 2'(MAX_SHRINK)) && (cfg_streams <= cfg_len);
        accept = cfg_load && !in_valid && legal;
    end

    pipe_counter #(.CW(STAGES)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (in_valid),
        .clear_i (accept),
        .cnt_o   (cnt),
        .run_o   (running)
    );

    stage_map #(.STAGES(STAGES), .STG_W(STG_W)) u_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_i       (cnt),
        .len_i       (r_q.mode.len),
        .sel_o       (stage_sel),
        .en_o        (stage_en),
        .out_stage_o (out_stage),
        .lat_o       (lat)
    );

    always_comb begin
        r_d = r_q;
        if (accept) begin
            r_d.mode.len = cfg_len;
            r_d.mode.str = cfg_streams;
            r_d.ovalid   = 1'b0;
        end else if ((running || in_valid) && cnt == lat - STAGES'(1)) begin
            r_d.ovalid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rate_shift = r_q.mode.len - r_q.mode.str;
    assign out_valid  = r_q.ovalid;

    // R8: no mode change while samples flow
    assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ($stable(out_stage) && $stable(rate_shift)));

    // R7: more streams than the length allows never changes the mode
    assert_illegal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && cfg_streams > cfg_len) |=> ($stable(out_stage) && $stable(rate_shift)));

    // R9: an accepted load restarts the frame
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!out_valid && stage_sel == '0));

    // R10: valid stays once raised until a load
    assert_valid_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !cfg_load) |=> out_valid);

    // R4: final stage lies within the supported range
    assert_outstage_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_stage <= STG_W'(STAGES)) && (out_stage >= STG_W'(STAGES - MAX_SHRINK)));
endmodule

// File: tb/sim_fft_mode_ctrl.sv
module sim_fft_mode_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          cfg_load = 1'b0;
    logic [1:0]    cfg_len = '0;
    logic [1:0]    cfg_streams = '0;
    logic [NS-1:0] stage_sel, stage_en;
    logic [3:0]    out_stage;
    logic [1:0]    rate_shift;
    logic          out_valid;

    int total = 0;
    int bad = 0;
    int k = 0;   // samples since first input (expected count)
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fft_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cfg_load(cfg_load),
        .cfg_len(cfg_len), .cfg_streams(cfg_streams), .stage_sel(stage_sel),
        .stage_en(stage_en), .out_stage(out_stage), .rate_shift(rate_shift),
        .out_valid(out_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [NS-1:0] exp_sel(input int cnt);
        logic [NS-1:0] r;
        for (int s = 1; s <= NS; s++) r[s-1] = 1'((cnt % 2048) >> (NS - s));
        return r;
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic load(input logic [1:0] l, input logic [1:0] s);
        cfg_len = l; cfg_streams = s; cfg_load = 1'b1;
        step();
        cfg_load = 1'b0;
    endtask

    task automatic check_mode(input string req, input int ostage, input int rs);
        check(req, 32'(out_stage), 32'(ostage));
        check(req, 32'(stage_en), 32'((1 << ostage) - 1));
        check(req, 32'(rate_shift), 32'(rs));
    endtask

    // run a frame to just past its latency, checking selects and valid
    task automatic run_frame(input string req, input int lat, input int stop);
        in_valid = 1'b1;
        k = 0;
        for (int i = 1; i <= stop; i++) begin
            step();
            k = i;
            if (i == 3) in_valid = 1'b0;  // R2: counter keeps running
            if (i == 1 || i == 2 || i == 5 || i == 1023 || i == 1024 || i == 1500 || i == 2048)
                check("R3 stage select", 32'(stage_sel), 32'(exp_sel(i)));
            if (i == lat - 1) check({req, " R10 valid early"}, 32'(out_valid), 32'd0);
            if (i == lat)     check({req, " R10 valid rise"}, 32'(out_valid), 32'd1);
        end
    endtask

    task automatic t_reset();
        check_mode("R1 reset mode", 11, 0);
        check("R1 reset sel", 32'(stage_sel), 32'd0);
        check("R1 reset valid", 32'(out_valid), 32'd0);
    endtask

    task automatic t_full();
        load(2'd0, 2'd0);
        check_mode("R4 2048x1", 11, 0);
        for (int i = 0; i < 4; i++) step();
        check("R2 idle hold", 32'(stage_sel), 32'd0);
        run_frame("R10 2048", 2047, 2049);
        check("R2 wrap", 32'(stage_sel), 32'(exp_sel(2049)));
    endtask

    task automatic t_quarter();
        load(2'd2, 2'd0);
        check_mode("R5 512x1", 9, 2);
        check("R9 clear sel", 32'(stage_sel), 32'd0);
        check("R9 clear valid", 32'(out_valid), 32'd0);
        run_frame("R10 512", 2044, 2045);
    endtask

    task automatic t_streams();
        load(2'd2, 2'd1);
        check_mode("R6 512x2", 9, 1);
        load(2'd1, 2'd1);
        check_mode("R6 1024x2", 10, 0);
        run_frame("R10 1024", 2046, 2046);
    endtask

    task automatic t_ignore();
        load(2'd3, 2'd0);
        k++;
        check_mode("R7 len 3 ignored", 10, 0);
        check("R7 count kept", 32'(stage_sel), 32'(exp_sel(k)));
        load(2'd0, 2'd2);
        k++;
        check_mode("R7 streams>len ignored", 10, 0);
        check("R7 valid kept", 32'(out_valid), 32'd1);
        in_valid = 1'b1;
        load(2'd0, 2'd0);
        in_valid = 1'b0;
        k++;
        check_mode("R8 load during input", 10, 0);
        check("R8 count kept", 32'(stage_sel), 32'(exp_sel(k)));
        check("R8 valid kept", 32'(out_valid), 32'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_full();
        t_quarter();
        t_streams();
        t_ignore();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule